// File: doc/BRIEF.md
# Fault-Tolerant Serialising Wire Link

This block joins a sending interface and a receiving interface through a bundle of N+R wires. R of those wires are spares. Any wire may be marked broken. The sender offers an N-bit word with a valid/ready handshake. When every bit can be given a working wire, the link runs in bypass mode: the word goes through a crossover in the same cycle, with no register on the path. When there are fewer working wires than data bits, the link runs in serial mode. It captures the word and spends K transfer cycles moving it. In each transfer cycle it applies a different crossover map that places a subset of the bits on working wires.

A transfer-cycle counter sits on each side of the wires. It picks the per-cycle map, and on the receiving side it also picks a load-enable mask. The receiver applies the transposed map, so each bit returns to its home position. It raises its valid output for one cycle once the word is whole. All maps, masks, K and the mode are configuration inputs. Computing them from a wire test result is the job of another block.

Back-pressure rules:
- The sender may only hand over a word in a cycle where `up_ready` is high. A word offered while `up_ready` is low is dropped, and the sender must hold it and offer it again.
- The receiving side cannot stall. `dn_valid` is a single-cycle pulse, and `dn_data` keeps its value until the next word is loaded.

The `LINK_STAGES` parameter inserts register stages on the wires. The receive-side counter start and the bypass valid are delayed by the same number of stages.

Top module: `fts_serial_link`

## Requirements
- R1: While reset is held, and right after it, `up_ready` is 1, `dn_valid` is 0 and `dn_data` is 0 (with `cfg_serial`=1).
- R2: With `cfg_serial`=0:
  - `up_ready` is always 1.
  - `dn_valid` equals `up_valid` in the same cycle.
  - `dn_data` is the word restored through map set 0 after broken wires are forced to 0.
- R3: With `cfg_serial`=1, a cycle where `up_valid` and `up_ready` are both 1 captures `up_data`. `up_ready` is then 0 for exactly K cycles and is 1 again in the following cycle.
- R4: A request made while `up_ready` is 0 has no effect. The word that arrives is the one captured first, and the timing is unchanged.
- R5: In transfer cycle k (counting from 0), `link_tx` carries data bit i on wire (i+R-j) mod (N+R) when `cfg_map` bit ((k*N+i)*(N+R-MMIN+1)+j) is 1. The index wraps from below 0 to the top wire. A wire that no bit selects is 0, and `link_tx` is 0 when serial mode is idle.
- R6: On the receive side, broken wires (a 1 in `wire_fault`) read as 0. Register bit i loads in transfer cycle k only when `cfg_en` bit (k*N+i) is 1; otherwise it keeps its value. The receive map is the transpose of the send map for the same k.
- R7: In serial mode, `dn_valid` is a one-cycle pulse in the cycle after the last transfer cycle, which is K+1 cycles after acceptance. `dn_data` then holds the full word.
- R8: A `cfg_cycles` value of 0 acts as K=1. A value above KMAX=ceil(N/MMIN) acts as KMAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous with clk |
| cfg_serial | input | 1 | 1 selects serial mode, 0 selects bypass |
| cfg_cycles | input | $clog2(KMAX+1) | Transfer cycle count K |
| cfg_map | input | KMAX*N*(N+R-MMIN+1) | Per-cycle one-hot crossover choices |
| cfg_en | input | KMAX*N | Per-cycle receive load masks |
| wire_fault | input | N+R | 1 marks a wire that reads as 0 at the receiver |
| up_valid | input | 1 | Sender offers a word |
| up_ready | output | 1 | Link accepts a word this cycle |
| up_data | input | N | Word from the sender |
| link_tx | output | N+R | Values driven onto the wires |
| dn_valid | output | 1 | Word delivered |
| dn_data | output | N | Restored word |

## Verification
Each side of the link holds its own counter. If one of them is wrong, the effect shows up at the ports within one transfer. A counter that drifts applies the wrong map on `link_tx` in that same cycle. It also misplaces the `dn_valid` pulse by a whole cycle, and `up_ready` returns early or late. A receive register that loads outside its mask shows a stale or foreign bit in `dn_data` at the next pulse. The bench model predicts all four outputs every cycle, so any such fault is caught in the first cycle where it differs.

// File: rtl/fts_pkg.sv
package fts_pkg;
  // Wire position reached by data bit i with choice j (or the reverse), on a ring of wn wires
  function automatic int ring_pos(input int i, input int r, input int j, input int wn);
    return ((i + r - j) % wn + wn) % wn;
  endfunction
endpackage

// File: rtl/fts_xbar_tx.sv
module fts_xbar_tx #(
  parameter int N    = 4,
  parameter int R    = 1,
  parameter int MMIN = 2,
  localparam int W   = N + R,
  localparam int J   = N + R - MMIN + 1
) (
  input  logic [N-1:0]   bits_i,
  input  logic [N*J-1:0] sel_i,
  output logic [W-1:0]   wires_o
);
  // One AND-OR one-hot multiplexer per wire
  for (genvar w = 0; w < W; w++) begin : g_wire
    logic [N-1:0] hit;
    for (genvar i = 0; i < N; i++) begin : g_bit
      localparam int SJ = fts_pkg::ring_pos(i, R, w, W);
      if (SJ < J) begin : g_reach
        assign hit[i] = sel_i[i*J+SJ] & bits_i[i];
      end else begin : g_none
        assign hit[i] = 1'b0;
      end
    end
    assign wires_o[w] = |hit;
  end
endmodule

// File: rtl/fts_xbar_rx.sv
module fts_xbar_rx #(
  parameter int N    = 4,
  parameter int R    = 1,
  parameter int MMIN = 2,
  localparam int W   = N + R,
  localparam int J   = N + R - MMIN + 1
) (
  input  logic [W-1:0]   wires_i,
  input  logic [N*J-1:0] sel_i,
  output logic [N-1:0]   bits_o
);
  // Transposed crossover: each bit picks back the wire it was placed on
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [J-1:0] pick;
    for (genvar j = 0; j < J; j++) begin : g_choice
      localparam int WP = fts_pkg::ring_pos(i, R, j, W);
      assign pick[j] = sel_i[i*J+j] & wires_i[WP];
    end
    assign bits_o[i] = |pick;
  end
endmodule

// File: rtl/fts_seq_ctr.sv
module fts_seq_ctr #(
  parameter int KMAX = 2,
  localparam int CW  = $clog2(KMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [CW-1:0] cycles_i,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] CNT_TOP = CW'(KMAX - 1);

  logic [CW:0] next_cnt;
  assign next_cnt = {1'b0, cnt_o} + (CW+1)'(1);
  assign last_o   = busy_o && ((next_cnt >= {1'b0, cycles_i}) || (cnt_o == CNT_TOP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt_o  <= '0;
    end else if (start_i) begin
      busy_o <= 1'b1;
      cnt_o  <= '0;
    end else if (busy_o) begin
      if (last_o) busy_o <= 1'b0;
      else        cnt_o  <= next_cnt[CW-1:0];
    end
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (cnt_o <= CNT_TOP));
  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !last_o && !start_i) |=> (busy_o && cnt_o == $past(cnt_o) + CW'(1)));
  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/fts_link_pipe.sv
module fts_link_pipe #(
  parameter int W      = 5,
  parameter int STAGES = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wires_i,
  input  logic         start_i,
  input  logic         bvalid_i,
  output logic [W-1:0] wires_o,
  output logic         start_o,
  output logic         bvalid_o
);
  if (STAGES == 0) begin : g_direct
    assign wires_o  = wires_i;
    assign start_o  = start_i;
    assign bvalid_o = bvalid_i;
  end else begin : g_regs
    logic [W+1:0] stage_q [STAGES];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
        stage_q[0] <= {start_i, bvalid_i, wires_i};
        for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
    end
    assign {start_o, bvalid_o, wires_o} = stage_q[STAGES-1];
  end
endmodule

// File: rtl/fts_serial_link.sv
module fts_serial_link #(
  parameter int N           = 4,
  parameter int R           = 1,
  parameter int MMIN        = 2,
  parameter int LINK_STAGES = 0,
  localparam int W    = N + R,
  localparam int J    = N + R - MMIN + 1,
  localparam int KMAX = (N + MMIN - 1) / MMIN,
  localparam int CW   = $clog2(KMAX + 1),
  localparam int SETW = N * J,
  localparam int MAPW = KMAX * SETW,
  localparam int ENW  = KMAX * N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_serial,
  input  logic [CW-1:0]   cfg_cycles,
  input  logic [MAPW-1:0] cfg_map,
  input  logic [ENW-1:0]  cfg_en,
  input  logic [W-1:0]    wire_fault,
  input  logic            up_valid,
  output logic            up_ready,
  input  logic [N-1:0]    up_data,
  output logic [W-1:0]    link_tx,
  output logic            dn_valid,
  output logic [N-1:0]    dn_data
);
  // ---------------- sending side ----------------
  logic          up_busy, up_last, ser_start;
  logic [CW-1:0] up_cnt;
  logic [N-1:0]  up_reg, tx_bits;
  logic [SETW-1:0] tx_sel;

  assign up_ready  = !cfg_serial || !up_busy;
  assign ser_start = up_valid && up_ready && cfg_serial;

  fts_seq_ctr #(.KMAX(KMAX)) up_ctr_i (
    .clk(clk), .rst_n(rst_n), .start_i(ser_start), .cycles_i(cfg_cycles),
    .busy_o(up_busy), .cnt_o(up_cnt), .last_o(up_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         up_reg <= '0;
    else if (ser_start) up_reg <= up_data;
  end

  always_comb begin
    tx_sel = cfg_map[SETW-1:0];
    if (cfg_serial) begin
      for (int k = 0; k < KMAX; k++)
        if (up_cnt == CW'(k)) tx_sel = cfg_map[k*SETW +: SETW];
    end
  end

  assign tx_bits = cfg_serial ? (up_busy ? up_reg : '0) : up_data;

  fts_xbar_tx #(.N(N), .R(R), .MMIN(MMIN)) tx_xbar_i (
    .bits_i(tx_bits), .sel_i(tx_sel), .wires_o(link_tx)
  );

  // ---------------- wires ----------------
  logic [W-1:0] rx_wires;
  logic         dn_start, byp_valid;

  fts_link_pipe #(.W(W), .STAGES(LINK_STAGES)) pipe_i (
    .clk(clk), .rst_n(rst_n),
    .wires_i(link_tx & ~wire_fault), .start_i(ser_start),
    .bvalid_i(up_valid && !cfg_serial),
    .wires_o(rx_wires), .start_o(dn_start), .bvalid_o(byp_valid)
  );

  // ---------------- receiving side ----------------
  logic            dn_busy, dn_last, dv_q;
  logic [CW-1:0]   dn_cnt;
  logic [SETW-1:0] rx_sel;
  logic [N-1:0]    rx_en, rx_bits, dn_reg;

  fts_seq_ctr #(.KMAX(KMAX)) dn_ctr_i (
    .clk(clk), .rst_n(rst_n), .start_i(dn_start), .cycles_i(cfg_cycles),
    .busy_o(dn_busy), .cnt_o(dn_cnt), .last_o(dn_last)
  );

  always_comb begin
    rx_sel = cfg_map[SETW-1:0];
    rx_en  = '0;
    if (cfg_serial) begin
      for (int k = 0; k < KMAX; k++)
        if (dn_cnt == CW'(k)) begin
          rx_sel = cfg_map[k*SETW +: SETW];
          rx_en  = cfg_en[k*N +: N];
        end
    end
  end

  fts_xbar_rx #(.N(N), .R(R), .MMIN(MMIN)) rx_xbar_i (
    .wires_i(rx_wires), .sel_i(rx_sel), .bits_o(rx_bits)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dn_reg <= '0;
      dv_q   <= 1'b0;
    end else begin
      dv_q <= dn_last;
      if (dn_busy) begin
        for (int i = 0; i < N; i++)
          if (rx_en[i]) dn_reg[i] <= rx_bits[i];
      end
    end
  end

  assign dn_valid = cfg_serial ? dv_q   : byp_valid;
  assign dn_data  = cfg_serial ? dn_reg : rx_bits;

  // R3
  start_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_start |=> (!up_ready || !cfg_serial));
  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_serial && dn_valid) |=> (!dn_valid || !cfg_serial));
  if (LINK_STAGES == 0) begin : g_align_chk
    // R7
    valid_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_serial && dn_valid) |-> $past(up_last));
  end
endmodule

// File: tb/fts_serial_link_tb_top.sv
module fts_serial_link_tb_top;
  localparam int N = 4, R = 1, MMIN = 2;
  localparam int W = N + R, J = N + R - MMIN + 1, KMAX = 2, CW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_serial;
  logic [CW-1:0] cfg_cycles;
  logic [KMAX*N*J-1:0] cfg_map;
  logic [KMAX*N-1:0] cfg_en;
  logic [W-1:0] wire_fault;
  logic up_valid, up_ready, dn_valid;
  logic [N-1:0] up_data, dn_data;
  logic [W-1:0] link_tx;

  always #5 clk = ~clk;

  fts_serial_link dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial), .cfg_cycles(cfg_cycles),
    .cfg_map(cfg_map), .cfg_en(cfg_en), .wire_fault(wire_fault),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .link_tx(link_tx), .dn_valid(dn_valid), .dn_data(dn_data)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // reference model state
  bit m_busy, m_dv;
  int m_cnt, m_k;
  logic [N-1:0] m_word, m_dreg;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ring(input int i, input int j);
    return ((i + R - j) % W + W) % W;
  endfunction

  function automatic logic [W-1:0] ref_tx(input logic [N-1:0] d, input int k);
    logic [W-1:0] t = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < J; j++)
        if (cfg_map[(k*N+i)*J+j] && d[i]) t[ring(i, j)] = 1'b1;
    return t;
  endfunction

  function automatic logic [N-1:0] ref_rx(input logic [W-1:0] wv, input int k);
    logic [N-1:0] b = '0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < J; j++)
        if (cfg_map[(k*N+i)*J+j] && wv[ring(i, j)]) b[i] = 1'b1;
    return b;
  endfunction

  task automatic route(input int k, input int i, input int w);
    cfg_map[(k*N+i)*J + ring(i, w)] = 1'b1;
  endtask

  task automatic clear_cfg();
    cfg_map = '0; cfg_en = '0; wire_fault = '0;
  endtask

  // One clock of stimulus with full comparison against the model
  task automatic step(input bit v, input logic [N-1:0] d);
    bit er, edv, last;
    logic [W-1:0] etx;
    logic [N-1:0] edd, rxb;
    up_valid = v; up_data = d;
    #1;
    if (!cfg_serial) begin
      er = 1; etx = ref_tx(d, 0); edv = v; edd = ref_rx(etx & ~wire_fault, 0);
    end else begin
      er = !m_busy; etx = m_busy ? ref_tx(m_word, m_cnt) : '0; edv = m_dv; edd = m_dreg;
    end
    check(up_ready === er, cfg_serial ? "R3 up_ready" : "R2 up_ready", 32'(up_ready), 32'(er));
    check(dn_valid === edv, cfg_serial ? "R7 dn_valid" : "R2 dn_valid", 32'(dn_valid), 32'(edv));
    check(link_tx === etx, "R5 link_tx", 32'(link_tx), 32'(etx));
    check(dn_data === edd, cfg_serial ? "R6 dn_data" : "R2 dn_data", 32'(dn_data), 32'(edd));
    @(posedge clk);
    if (cfg_serial) begin
      last = m_busy && (m_cnt == m_k - 1);
      if (m_busy) begin
        rxb = ref_rx(etx & ~wire_fault, m_cnt);
        for (int i = 0; i < N; i++) if (cfg_en[m_cnt*N+i]) m_dreg[i] = rxb[i];
        if (last) m_busy = 0; else m_cnt++;
      end else if (v) begin
        m_busy = 1; m_cnt = 0; m_word = d;
        m_k = (cfg_cycles == 0) ? 1 : ((int'(cfg_cycles) > KMAX) ? KMAX : int'(cfg_cycles));
      end
      m_dv = last;
    end else begin
      m_dv = 0;
    end
    @(negedge clk);
  endtask

  task automatic expect_out(input string tag, input bit dv, input logic [N-1:0] dd);
    #1;
    check(dn_valid === dv, tag, 32'(dn_valid), 32'(dv));
    check(dn_data === dd, tag, 32'(dn_data), 32'(dd));
  endtask

  task automatic doc_cfg(input bit en0_bit0_k1);
    clear_cfg();
    wire_fault = 5'b10010;           // wires 4 and 1 broken
    route(0, 3, 3); route(0, 2, 2); route(0, 1, 0);
    route(1, 0, 0);
    cfg_en = {3'b000, en0_bit0_k1, 4'b1110};
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    rst_n = 0; cfg_serial = 1; cfg_cycles = 2; up_valid = 0; up_data = '0;
    clear_cfg();
    m_busy = 0; m_dv = 0; m_cnt = 0; m_k = 1; m_word = '0; m_dreg = '0;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(up_ready === 1'b1, "R1 up_ready", 32'(up_ready), 1);
    check(dn_valid === 1'b0, "R1 dn_valid", 32'(dn_valid), 0);
    check(dn_data === '0, "R1 dn_data", 32'(dn_data), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_out("R1 after reset", 0, '0);

    // R2 bypass, straight map, no broken wire
    cfg_serial = 0; clear_cfg();
    for (int i = 0; i < N; i++) route(0, i, i + 1);
    step(1, 4'hA); step(0, 4'h5); step(1, 4'h3); step(1, 4'hF);
    // R2 bypass with wire 2 broken, bits 1 and 0 shifted right
    wire_fault = 5'b00100;
    cfg_map = '0; route(0, 3, 4); route(0, 2, 3); route(0, 1, 1); route(0, 0, 0);
    step(1, 4'h6); step(1, 4'h9);
    #1 check(dn_data === 4'h9 && dn_valid, "R2 repaired word", 32'(dn_data), 32'h9);
    step(0, 4'h0);

    // R7 serial, two cycles, wires 4 and 1 broken
    cfg_serial = 1; cfg_cycles = 2; doc_cfg(1'b1);
    step(1, 4'hB); step(0, 4'h0); step(0, 4'h0);
    expect_out("R7 word after K+1", 1, 4'hB);
    step(0, 4'h0);
    expect_out("R7 one-cycle pulse", 0, 4'hB);

    // R4 requests while busy are ignored
    step(1, 4'h6); step(1, 4'h1); step(1, 4'hE);
    expect_out("R4 first word kept", 1, 4'h6);
    // back-to-back accept on the delivery cycle
    step(1, 4'h4); step(0, 4'h0); step(0, 4'h0);
    expect_out("R3 back-to-back", 1, 4'h4);
    step(0, 4'h0);

    // R5 wrap-around: wires 0..2 broken, bits 1 and 0 wrap to wires 4 and 3
    clear_cfg(); wire_fault = 5'b00111;
    route(0, 3, 4); route(0, 2, 3); route(1, 1, 4); route(1, 0, 3);
    cfg_en = 8'b0011_1100;
    step(1, 4'h7); step(0, 4'h0); step(0, 4'h0);
    expect_out("R5 wrapped word", 1, 4'h7);
    step(1, 4'hC); step(0, 4'h0); step(0, 4'h0); step(0, 4'h0);

    // R6 bit 0 masked in cycle 1 keeps its previous value
    doc_cfg(1'b0);
    step(1, 4'h1); step(0, 4'h0); step(0, 4'h0);
    expect_out("R6 masked bit held", 1, 4'h0);
    step(1, 4'hE); step(0, 4'h0); step(0, 4'h0);
    expect_out("R6 masked bit held", 1, 4'hE);
    step(0, 4'h0);

    // R8 K=0 acts as one cycle, K=3 acts as KMAX
    clear_cfg();
    for (int i = 0; i < N; i++) route(0, i, i + 1);
    cfg_en = 8'h0F; cfg_cycles = 0;
    step(1, 4'hD); step(0, 4'h0);
    expect_out("R8 K=0 as one", 1, 4'hD);
    step(0, 4'h0);
    doc_cfg(1'b1); cfg_cycles = 3;
    step(1, 4'h5); step(0, 4'h0); step(0, 4'h0);
    expect_out("R8 K=3 clamped", 1, 4'h5);
    step(0, 4'h0); step(0, 4'h0);

    finished = 1;
    report();
  end
endmodule